// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block turns one burst request into the list of column addresses that a DDR2-style memory walks through during that burst. A request gives a starting column, a burst-length code, a burst order (sequential or interleaved) and an auto-precharge flag. The block stores these when the request is accepted. It then emits one column address per data beat, with a valid strobe, and marks the final beat with a last strobe. The auto-precharge flag stays with every beat of the burst.

The address walks only inside the block of columns that the burst length lines up on. The low bits change from beat to beat and the bits above them stay at the starting column's value. The sequential order counts the low bits upward from the start and wraps at the block boundary. The interleaved order forms each beat's low bits as the start's low bits XOR the beat number. A request with a burst-length code that names neither 4 nor 8 raises a one-cycle error and produces no beats. A request that arrives while a burst is running is dropped.

Top module: `burst_col_seq`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), beat_valid_o, beat_last_o and cfg_err_o are all low.
- R2: A request accepted at a rising edge with blen_code_i = 3'b010 yields exactly 4 beats, and one with 3'b011 yields exactly 8 beats. The beats are on consecutive cycles, the first is visible right after that edge, and beat_last_o is high on the final beat only.
- R3: With order_i = 0 (sequential), the low bits of beat n are (start low bits + n) modulo the burst length. The low bits are bits 1:0 for length 4 and bits 2:0 for length 8.
- R4: With order_i = 1 (interleaved), the low bits of beat n are the start low bits XOR n, over the same low bits as in R3.
- R5: The column bits above the low bits of R3 equal the starting column's bits on every beat of a burst.
- R6: A start_i that is high while beat_valid_o is high, the last beat included, is ignored. It does not alter the running burst's addresses, length or flag, and it does not raise cfg_err_o. A request is accepted only in a cycle with no beat.
- R7: A request accepted while idle with a blen_code_i other than 3'b010 or 3'b011 sets cfg_err_o high for exactly the next cycle and produces no beat.
- R8: beat_autopre_o on every beat equals the autopre_i value captured when the burst was accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Burst request |
| start_col_i | input | 10 | Starting column of the burst |
| blen_code_i | input | 3 | Burst-length code: 3'b010 for 4 beats, 3'b011 for 8 beats |
| order_i | input | 1 | Burst order: 0 sequential, 1 interleaved |
| autopre_i | input | 1 | Auto-precharge request for this burst |
| beat_valid_o | output | 1 | A beat address is presented |
| beat_col_o | output | 10 | Column address of the current beat |
| beat_last_o | output | 1 | Current beat is the final one of the burst |
| beat_autopre_o | output | 1 | Auto-precharge flag of the running burst |
| cfg_err_o | output | 1 | One-cycle pulse for a rejected burst-length code |

## Verification
A wrong beat counter shows up at the ports within one burst. The burst is the wrong length, beat_last_o lands on the wrong beat, or a 4-beat burst reuses addresses from an 8-beat walk. The bench also checks that no beat appears in the cycle right after a last beat. A wrongly stored start column or order setting corrupts beat_col_o from the first beat on, so every beat is compared with an address the bench computes for itself. A request that leaks through while busy changes the addresses, the flag or the error pulse in the very next cycle, and the bench drives such requests with random contents and a random length code.

// File: rtl/bcs_pkg.sv
// Package: shared encodings for the burst column address sequencer.
// Assumes: the burst-length codes are fixed at design time; the order
// flag is a single bit.
package bcs_pkg;

    localparam int unsigned BLEN_CODE_W = 3;

    localparam logic [BLEN_CODE_W-1:0] BLEN_CODE_4 = 3'b010;
    localparam logic [BLEN_CODE_W-1:0] BLEN_CODE_8 = 3'b011;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_ILV = 1'b1
    } order_e;

    typedef struct packed {
        logic   bl8;
        order_e ord;
        logic   autopre;
    } burst_cfg_t;

endpackage

// File: rtl/bcs_len_decode.sv
// Module: bcs_len_decode
// Decodes the burst-length code into a valid flag and a long-burst select.
// Assumes: only two lengths exist, the full length and half of it.
module bcs_len_decode
    import bcs_pkg::*;
(
    input  logic [BLEN_CODE_W-1:0] code_i,
    output logic                   ok_o,
    output logic                   bl8_o
);

    // Classify the code as short, long or invalid.
    always_comb begin
        bl8_o = (code_i == BLEN_CODE_8);
        ok_o  = (code_i == BLEN_CODE_4) || bl8_o;
    end

endmodule

// File: rtl/bcs_beat_ctr.sv
// Module: bcs_beat_ctr
// Counts the beats of a running burst and flags the final one.
// Assumes: launch_i is raised only while idle; bl8_i is stable
// for the whole burst.
module bcs_beat_ctr #(
    parameter int unsigned MAX_BEATS = 8,
    localparam int unsigned CNT_W    = $clog2(MAX_BEATS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_i,
    input  logic             bl8_i,
    output logic             busy_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o
);

    localparam logic [CNT_W-1:0] TERM_LONG  = CNT_W'(MAX_BEATS - 1);
    localparam logic [CNT_W-1:0] TERM_SHORT = CNT_W'(MAX_BEATS / 2 - 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    // Final beat is reached when the counter meets the selected terminal.
    always_comb begin
        last_o = busy_q && (cnt_q == (bl8_i ? TERM_LONG : TERM_SHORT));
    end

    // Start, advance and end the beat count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (launch_i) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (last_o) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q  <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign busy_o = busy_q;
    assign cnt_o  = cnt_q;

    // R2: the cycle after the final beat carries no beat
    p_end_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> !busy_o);

    // R2: beats before the last advance the count by one each cycle
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !last_o) |=> (busy_o && cnt_o == $past(cnt_o) + CNT_W'(1)));

    // R6: a new burst is never launched over a running one
    p_launch_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |-> !busy_o);

endmodule

// File: rtl/bcs_col_order.sv
// Module: bcs_col_order
// Forms the column address of one beat from the stored start column.
// Assumes: beat_i stays below the burst length selected by bl8_i.
module bcs_col_order #(
    parameter int unsigned COL_W = 10,
    parameter int unsigned CNT_W = 3
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [CNT_W-1:0] beat_i,
    input  logic             bl8_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);

    logic [CNT_W-1:0] mask;
    logic [CNT_W-1:0] base_lo;
    logic [CNT_W-1:0] mixed;

    // Pick the varying low bits, step them, and keep the rest of the start.
    always_comb begin
        mask    = bl8_i ? {CNT_W{1'b1}} : {1'b0, {(CNT_W-1){1'b1}}};
        base_lo = base_i[CNT_W-1:0];
        mixed   = ilv_i ? (base_lo ^ beat_i) : (base_lo + beat_i);
        col_o   = {base_i[COL_W-1:CNT_W], (base_lo & ~mask) | (mixed & mask)};
    end

endmodule

// File: rtl/burst_col_seq.sv
// Module: burst_col_seq (top)
// Accepts a burst request while idle, stores its settings and walks the
// column addresses of the burst one beat per cycle. A request with an
// invalid length code is rejected with a one-cycle error pulse.
// Assumes: requests arriving during a burst are dropped, not queued.
module burst_col_seq
    import bcs_pkg::*;
#(
    parameter int unsigned COL_W     = 10,
    parameter int unsigned MAX_BEATS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [COL_W-1:0]       start_col_i,
    input  logic [BLEN_CODE_W-1:0] blen_code_i,
    input  logic                   order_i,
    input  logic                   autopre_i,
    output logic                   beat_valid_o,
    output logic [COL_W-1:0]       beat_col_o,
    output logic                   beat_last_o,
    output logic                   beat_autopre_o,
    output logic                   cfg_err_o
);

    localparam int unsigned CNT_W = $clog2(MAX_BEATS);

    logic             code_ok;
    logic             code_bl8;
    logic             busy;
    logic [CNT_W-1:0] cnt;
    logic             accept;
    logic             launch;
    logic [COL_W-1:0] base_q;
    burst_cfg_t       cfg_q;
    logic             err_q;

    bcs_len_decode u_dec (
        .code_i (blen_code_i),
        .ok_o   (code_ok),
        .bl8_o  (code_bl8)
    );

    // A request counts only while no burst runs; a good code launches it.
    always_comb begin
        accept = start_i && !busy;
        launch = accept && code_ok;
    end

    // Capture the burst settings and the rejection pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cfg_q  <= '{bl8: 1'b0, ord: ORD_SEQ, autopre: 1'b0};
            err_q  <= 1'b0;
        end else begin
            err_q <= accept && !code_ok;
            if (launch) begin
                base_q        <= start_col_i;
                cfg_q.bl8     <= code_bl8;
                cfg_q.ord     <= order_e'(order_i);
                cfg_q.autopre <= autopre_i;
            end
        end
    end

    bcs_beat_ctr #(
        .MAX_BEATS (MAX_BEATS)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (launch),
        .bl8_i    (cfg_q.bl8),
        .busy_o   (busy),
        .cnt_o    (cnt),
        .last_o   (beat_last_o)
    );

    bcs_col_order #(
        .COL_W (COL_W),
        .CNT_W (CNT_W)
    ) u_ord (
        .base_i (base_q),
        .beat_i (cnt),
        .bl8_i  (cfg_q.bl8),
        .ilv_i  (cfg_q.ord == ORD_ILV),
        .col_o  (beat_col_o)
    );

    assign beat_valid_o   = busy;
    assign beat_autopre_o = cfg_q.autopre;
    assign cfg_err_o      = err_q;

    // R7: a rejected request produces no beat in the pulse cycle
    p_err_no_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> !beat_valid_o);

    // R7: the error pulse lasts a single cycle
    p_err_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |=> !cfg_err_o);

    // R5: the bits above the low bits hold across consecutive beats
    p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && $past(beat_valid_o)) |->
        (beat_col_o[COL_W-1:CNT_W] == $past(beat_col_o[COL_W-1:CNT_W])));

    // R8: the auto-precharge flag holds across a burst
    p_autopre_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && $past(beat_valid_o)) |-> $stable(beat_autopre_o));

    // R2: a burst opens only in the cycle after a request
    p_open_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(beat_valid_o) |-> $past(start_i));

endmodule

// File: tb/sim_burst_col_seq.sv
// Bench: directed corner cases plus seeded random bursts, each beat
// compared with an address computed from the requirements.
module sim_burst_col_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [9:0] col = '0;
    logic [2:0] code = '0;
    logic       ord = 1'b0;
    logic       ap = 1'b0;
    logic       v, last, apo, err;
    logic [9:0] colo;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    burst_col_seq u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start),
        .start_col_i    (col),
        .blen_code_i    (code),
        .order_i        (ord),
        .autopre_i      (ap),
        .beat_valid_o   (v),
        .beat_col_o     (colo),
        .beat_last_o    (last),
        .beat_autopre_o (apo),
        .cfg_err_o      (err)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_col(input int b, input int n, input bit bl8,
                                   input bit ilv);
        int bl = bl8 ? 8 : 4;
        int lo = b % bl;
        int nl = ilv ? (lo ^ n) : ((lo + n) % bl);
        return b - lo + nl;
    endfunction

    // Issue a good burst and check every beat; junk requests while busy.
    task automatic do_burst(input logic [9:0] c, input logic [2:0] k,
                            input bit o, input bit a, input bit junk);
        int bl;
        bit bl8;
        bl8 = (k == 3'b011);
        bl  = bl8 ? 8 : 4;
        @(negedge clk);
        start = 1'b1; col = c; code = k; ord = o; ap = a;
        for (int n = 0; n < bl; n++) begin
            @(negedge clk);
            if (junk && n != bl - 1) begin
                start = 1'b1;
                col   = 10'($urandom);
                code  = 3'($urandom);
                ord   = ~o;
                ap    = ~a;
            end else begin
                start = 1'b0;
            end
            check(v == 1'b1, "R2", "valid on beat", int'(v), 1);
            check(colo == 10'(exp_col(int'(c), n, bl8, o)),
                  o ? "R4" : "R3", "beat column", int'(colo),
                  exp_col(int'(c), n, bl8, o));
            check(colo[9:3] == c[9:3], "R5", "upper bits", int'(colo[9:3]),
                  int'(c[9:3]));
            check(last == (n == bl - 1), "R2", "last flag", int'(last),
                  int'(n == bl - 1));
            check(apo == a, "R8", "autopre flag", int'(apo), int'(a));
            if (junk)
                check(err == 1'b0, "R6", "no error while busy", int'(err), 0);
        end
        @(negedge clk);
        check(v == 1'b0, "R2", "no beat after last", int'(v), 0);
        if (junk)
            check(err == 1'b0, "R6", "ignored request left no error",
                  int'(err), 0);
    endtask

    // Issue a request with an invalid length code.
    task automatic do_bad(input logic [2:0] k);
        @(negedge clk);
        start = 1'b1; col = 10'($urandom); code = k;
        @(negedge clk);
        start = 1'b0;
        check(err == 1'b1, "R7", "error pulse", int'(err), 1);
        check(v == 1'b0, "R7", "no beat on reject", int'(v), 0);
        @(negedge clk);
        check(err == 1'b0, "R7", "pulse one cycle", int'(err), 0);
        check(v == 1'b0, "R7", "still no beat", int'(v), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog act=0 exp=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        // R1: reset state
        start = 1'b1; code = 3'b010;
        repeat (3) @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(v == 1'b0, "R1", "valid after reset", int'(v), 0);
        check(last == 1'b0, "R1", "last after reset", int'(last), 0);
        check(err == 1'b0, "R1", "error after reset", int'(err), 0);
        rst_n = 1'b1;

        // Directed corners: wrap in both orders and at the top column.
        do_burst(10'd2, 3'b010, 1'b0, 1'b0, 1'b0);
        do_burst(10'd5, 3'b011, 1'b1, 1'b1, 1'b0);
        do_burst(10'h3FF, 3'b011, 1'b0, 1'b1, 1'b1);
        do_burst(10'h3FF, 3'b010, 1'b1, 1'b0, 1'b1);
        do_burst(10'd0, 3'b011, 1'b1, 1'b0, 1'b0);
        do_bad(3'b000);
        do_bad(3'b001);
        do_bad(3'b111);
        do_burst(10'd6, 3'b010, 1'b0, 1'b1, 1'b1);

        // Random bursts, some rejected.
        for (int i = 0; i < 300; i++) begin
            int sel = int'($urandom % 10);
            if (sel == 0) begin
                logic [2:0] k;
                k = 3'($urandom);
                if (k == 3'b010 || k == 3'b011) k = 3'b100;
                do_bad(k);
            end else begin
                do_burst(10'($urandom), (sel < 5) ? 3'b010 : 3'b011,
                         1'($urandom), 1'($urandom), 1'($urandom));
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule